// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external memory cycles for a 16-bit controller core over one shared address/data bus. The core presents an address, write data, a read/write flag, an instruction-fetch flag and an access size. The block drives the address onto the bus, then either releases the bus for read data or drives the write data. It generates the read strobe, the write strobe, an address strobe and a fetch-type indicator.

The address strobe has two meanings, chosen by a configuration input. In one mode it is a short active-high latch-enable pulse during the address phase. In the other mode it is an active-low "address valid" level that covers the address and transfer phases and returns high when the cycle finishes.

The bus width is taken from a pin when each request is accepted, but only if that pin is enabled. A word access on an 8-bit cycle is split into two byte cycles. The block also produces a clock output at half the input clock rate.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is low and after it, when no request is pending, rd_n and wr_n are 1, bus_ad_oe is 0, fetch_ind is 0, req_busy is 0, and astb shows its idle level: 0 when cfg_ale_mode=1 and 1 when cfg_ale_mode=0.
- R2: rd_n is 0 only during the strobe and data phases of a read cycle. During those phases bus_ad_oe is 0.
- R3: wr_n is 0 only during the strobe and data phases of a write cycle. During those phases the bus carries the write data. On an 8-bit cycle the bus carries the selected byte on bits [7:0], with zeros on bits [15:8]. On a 16-bit word cycle it carries the full word.
- R4: When cfg_ale_mode=1, astb is 1 during the address phase and 0 in every other cycle.
- R5: When cfg_ale_mode=0, astb is 0 during the address, strobe and data phases, and 1 during the release phase and while idle.
- R6: During every phase of an access, fetch_ind equals req_fetch as captured at acceptance. An access flagged as data, such as a configuration byte or a vector read, gives 0.
- R7: When cfg_width_en=1, pin_buswide is sampled at acceptance. A 1 gives a single 16-bit cycle for a word access. A 0 gives 8-bit cycles.
- R8: When cfg_width_en=0, pin_buswide has no effect, and every word access is split into two 8-bit cycles.
- R9: A split word access runs one byte cycle at the address with bit 0 cleared, then one at the address with bit 0 set. On a read, the first byte goes to rsp_rdata[7:0] and the second to rsp_rdata[15:8], each taken from bus bits [7:0]. A byte read returns zeros in rsp_rdata[15:8].
- R10: A request is accepted only when req_busy=0. req_valid is ignored while busy. req_busy stays 1 until the last cycle of the access ends. req_done is a single-cycle pulse in the first idle cycle, and rsp_rdata is valid then.
- R11: When cfg_clkout_dis=0, clk_half toggles on every input clock edge, giving half frequency with 50% duty. When cfg_clkout_dis=1, clk_half is held at 0.
- R12: Each byte or word cycle has four phases of one clock each: address (the bus drives the cycle address), strobe, data, and release (the bus is released). Read data is sampled at the end of the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests an access |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_word | input | 1 | 1 = 16-bit word access, 0 = byte |
| req_busy | output | 1 | Access in progress |
| req_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Assembled read data |
| cfg_ale_mode | input | 1 | 1 = latch-enable pulse, 0 = address-valid level |
| cfg_width_en | input | 1 | Enables the bus-width pin |
| cfg_clkout_dis | input | 1 | 1 holds the clock output low |
| pin_buswide | input | 1 | Bus-width pin, 1 = 16-bit |
| bus_ad_i | input | 16 | Bus value read back from the pads |
| bus_ad_o | output | 16 | Bus value driven to the pads |
| bus_ad_oe | output | 1 | Bus output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| astb | output | 1 | Address strobe (latch-enable pulse or address-valid level) |
| fetch_ind | output | 1 | Fetch-type indicator |
| clk_half | output | 1 | Half-rate clock output |

## Verification
The assertions check, on every cycle, the relations between pins:
- The two strobes are never low together.
- The bus is released whenever the read strobe is low.
- The idle outputs are quiet.
- The astb level during a transfer is correct in each mode.
- The done pulse lasts one cycle.
- The clock output toggles or is held as configured.

Only the bench scenarios can show the following:
- The correct address sequence of a split access.
- How the read bytes are assembled.
- That the width pin is ignored when disabled.
- That requests are dropped while busy.
- The exact phase timing against a reference model.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  // Bus cycle phases; one input clock per active phase.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_STRB = 3'd2,
    PH_DATA = 3'd3,
    PH_REL  = 3'd4
  } phase_e;

endpackage

// File: rtl/ebc_clkdiv.sv
module ebc_clkdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic ck_o
);

  logic ck_q;
  logic ck_d;

  always_comb begin
    if (hold) ck_d = 1'b0;
    else      ck_d = ~ck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_q <= 1'b0;
    else        ck_q <= ck_d;
  end

  assign ck_o = ck_q;

endmodule

// File: rtl/ebc_req_reg.sv
module ebc_req_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         write_i,
  input  logic         fetch_i,
  input  logic         word_i,
  input  logic         wide_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wdata_o,
  output logic         write_o,
  output logic         fetch_o,
  output logic         word_o,
  output logic         wide_o,
  output logic         split_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      wdata_o <= '0;
      write_o <= 1'b0;
      fetch_o <= 1'b0;
      word_o  <= 1'b0;
      wide_o  <= 1'b0;
    end else if (load) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      write_o <= write_i;
      fetch_o <= fetch_i;
      word_o  <= word_i;
      wide_o  <= wide_i;
    end
  end

  // A word on a narrow bus needs two byte cycles.
  assign split_o = word_o & ~wide_o;

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   split,
  output phase_e phase,
  output logic   beat,
  output logic   done
);

  phase_e phase_q, phase_d;
  logic   beat_q,  beat_d;
  logic   done_q,  done_d;
  logic   last_beat;

  assign last_beat = ~split | beat_q;

  always_comb begin
    phase_d = phase_q;
    beat_d  = beat_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ADDR;
          beat_d  = 1'b0;
        end
      end
      PH_ADDR: phase_d = PH_STRB;
      PH_STRB: phase_d = PH_DATA;
      PH_DATA: phase_d = PH_REL;
      PH_REL: begin
        if (last_beat) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          phase_d = PH_ADDR;
          beat_d  = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      beat_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      beat_q  <= beat_d;
      done_q  <= done_d;
    end
  end

  assign phase = phase_q;
  assign beat  = beat_q;
  assign done  = done_q;

endmodule

// File: rtl/ebc_pin_drv.sv
module ebc_pin_drv
  import ebc_pkg::*;
#(
  parameter int W = 16
) (
  input  phase_e       phase,
  input  logic         beat,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  input  logic         write,
  input  logic         fetch,
  input  logic         word,
  input  logic         wide,
  input  logic         split,
  input  logic         ale_mode,
  output logic [W-1:0] ad_o,
  output logic         ad_oe,
  output logic         rd_n,
  output logic         wr_n,
  output logic         astb,
  output logic         fetch_o
);

  localparam int HALF = W / 2;

  logic [W-1:0]    cyc_addr;
  logic [W-1:0]    lane;
  logic [HALF-1:0] sel_byte;

  always_comb begin
    cyc_addr = addr;
    if (split) cyc_addr[0] = beat;
  end

  always_comb begin
    sel_byte = beat ? wdata[W-1:HALF] : wdata[HALF-1:0];
    if (word && wide) lane = wdata;
    else              lane = {{(W-HALF){1'b0}}, sel_byte};
  end

  always_comb begin
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    ad_oe   = 1'b0;
    ad_o    = '0;
    astb    = ~ale_mode;
    fetch_o = 1'b0;
    case (phase)
      PH_ADDR: begin
        ad_oe   = 1'b1;
        ad_o    = cyc_addr;
        astb    = ale_mode;
        fetch_o = fetch;
      end
      PH_STRB, PH_DATA: begin
        rd_n    = write;
        wr_n    = ~write;
        ad_oe   = write;
        ad_o    = write ? lane : '0;
        astb    = 1'b0;
        fetch_o = fetch;
      end
      PH_REL: begin
        fetch_o = fetch;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ebc_rdata.sv
module ebc_rdata
  import ebc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_e       phase,
  input  logic         beat,
  input  logic         write,
  input  logic         word,
  input  logic         wide,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] rdata
);

  localparam int HALF = W / 2;

  logic         cap_en;
  logic [W-1:0] rdata_d;

  assign cap_en = (phase == PH_DATA) && !write;

  always_comb begin
    rdata_d = rdata;
    if (word && wide)  rdata_d = bus_i;
    else if (beat)     rdata_d[W-1:HALF] = bus_i[HALF-1:0];
    else               rdata_d = {{(W-HALF){1'b0}}, bus_i[HALF-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= rdata_d;
  end

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  input  logic         req_write,
  input  logic         req_fetch,
  input  logic         req_word,
  output logic         req_busy,
  output logic         req_done,
  output logic [W-1:0] rsp_rdata,
  input  logic         cfg_ale_mode,
  input  logic         cfg_width_en,
  input  logic         cfg_clkout_dis,
  input  logic         pin_buswide,
  input  logic [W-1:0] bus_ad_i,
  output logic [W-1:0] bus_ad_o,
  output logic         bus_ad_oe,
  output logic         rd_n,
  output logic         wr_n,
  output logic         astb,
  output logic         fetch_ind,
  output logic         clk_half
);

  phase_e       phase;
  logic         beat;
  logic         start;
  logic [W-1:0] r_addr, r_wdata;
  logic         r_write, r_fetch, r_word, r_wide, r_split;

  assign req_busy = (phase != PH_IDLE);
  assign start    = req_valid & ~req_busy;

  ebc_req_reg #(.W(W)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .addr_i  (req_addr),
    .wdata_i (req_wdata),
    .write_i (req_write),
    .fetch_i (req_fetch),
    .word_i  (req_word),
    .wide_i  (cfg_width_en & pin_buswide),
    .addr_o  (r_addr),
    .wdata_o (r_wdata),
    .write_o (r_write),
    .fetch_o (r_fetch),
    .word_o  (r_word),
    .wide_o  (r_wide),
    .split_o (r_split)
  );

  ebc_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .split (r_split),
    .phase (phase),
    .beat  (beat),
    .done  (req_done)
  );

  ebc_pin_drv #(.W(W)) u_pins (
    .phase    (phase),
    .beat     (beat),
    .addr     (r_addr),
    .wdata    (r_wdata),
    .write    (r_write),
    .fetch    (r_fetch),
    .word     (r_word),
    .wide     (r_wide),
    .split    (r_split),
    .ale_mode (cfg_ale_mode),
    .ad_o     (bus_ad_o),
    .ad_oe    (bus_ad_oe),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .astb     (astb),
    .fetch_o  (fetch_ind)
  );

  ebc_rdata #(.W(W)) u_rdata (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .beat  (beat),
    .write (r_write),
    .word  (r_word),
    .wide  (r_wide),
    .bus_i (bus_ad_i),
    .rdata (rsp_rdata)
  );

  ebc_clkdiv u_ckdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (cfg_clkout_dis),
    .ck_o  (clk_half)
  );

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker (
  input logic clk,
  input logic rst_n,
  input logic req_busy,
  input logic req_done,
  input logic cfg_ale_mode,
  input logic cfg_clkout_dis,
  input logic bus_ad_oe,
  input logic rd_n,
  input logic wr_n,
  input logic astb,
  input logic fetch_ind,
  input logic clk_half
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R3

  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_ad_oe); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |-> (rd_n && wr_n && !bus_ad_oe && !fetch_ind)); // R1

  AST_ALE_LOW_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ale_mode && (!rd_n || !wr_n)) |-> !astb); // R4

  AST_ADV_LOW_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ale_mode && (!rd_n || !wr_n)) |-> !astb); // R5

  AST_ADV_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ale_mode && !req_busy) |-> astb); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !req_busy); // R10

  AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clkout_dis |=> (clk_half != $past(clk_half))); // R11

  AST_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clkout_dis |=> !clk_half); // R11

endmodule

bind ext_bus_ctrl ebc_checker u_chk (.*);

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_write, req_fetch, req_word;
  logic [W-1:0] req_addr, req_wdata;
  logic         req_busy, req_done;
  logic [W-1:0] rsp_rdata;
  logic         cfg_ale_mode, cfg_width_en, cfg_clkout_dis, pin_buswide;
  logic [W-1:0] bus_ad_i, bus_ad_o;
  logic         bus_ad_oe, rd_n, wr_n, astb, fetch_ind, clk_half;

  ext_bus_ctrl #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_fetch(req_fetch),
    .req_word(req_word), .req_busy(req_busy), .req_done(req_done),
    .rsp_rdata(rsp_rdata), .cfg_ale_mode(cfg_ale_mode),
    .cfg_width_en(cfg_width_en), .cfg_clkout_dis(cfg_clkout_dis),
    .pin_buswide(pin_buswide), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .rd_n(rd_n), .wr_n(wr_n), .astb(astb),
    .fetch_ind(fetch_ind), .clk_half(clk_half)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic         rd_n, wr_n, oe, astb, fetch, busy, done, chk_rd;
    logic [W-1:0] ad, rd, din;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   idle_now;
  logic exp_ck;

  function automatic logic [W-1:0] mem(input logic [W-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_e();
    exp_t e;
    e.rd_n = 1; e.wr_n = 1; e.oe = 0; e.astb = ~cfg_ale_mode; e.fetch = 0;
    e.busy = 0; e.done = 0; e.chk_rd = 0; e.ad = '0; e.rd = '0; e.din = '0;
    e.tag = "R1";
    return e;
  endfunction

  task automatic push_cycle(input logic [W-1:0] a, input logic [W-1:0] lane,
                            input logic wr, input logic f, input string tag);
    exp_t e;
    e = idle_e(); e.busy = 1; e.fetch = f; e.tag = tag; e.din = mem(a);
    // address phase
    e.oe = 1; e.ad = a; e.astb = cfg_ale_mode;
    q.push_back(e);
    // strobe and data phases
    e.oe = wr; e.ad = lane; e.astb = 0; e.rd_n = wr; e.wr_n = ~wr;
    q.push_back(e);
    q.push_back(e);
    // release phase
    e.oe = 0; e.rd_n = 1; e.wr_n = 1; e.astb = ~cfg_ale_mode;
    q.push_back(e);
  endtask

  task automatic tick();
    exp_t e;
    @(negedge clk);
    exp_ck = cfg_clkout_dis ? 1'b0 : ~exp_ck;
    chk("R11 clk_half", {15'd0, clk_half}, {15'd0, exp_ck});
    if (q.size() > 0) e = q.pop_front();
    else              e = idle_e();
    chk({e.tag, " R2 rd_n"}, {15'd0, rd_n}, {15'd0, e.rd_n});
    chk({e.tag, " R3 wr_n"}, {15'd0, wr_n}, {15'd0, e.wr_n});
    chk({e.tag, " R12 oe"}, {15'd0, bus_ad_oe}, {15'd0, e.oe});
    if (e.oe) chk({e.tag, " R12 bus"}, bus_ad_o, e.ad);
    chk({e.tag, cfg_ale_mode ? " R4 astb" : " R5 astb"}, {15'd0, astb}, {15'd0, e.astb});
    chk({e.tag, " R6 fetch"}, {15'd0, fetch_ind}, {15'd0, e.fetch});
    chk({e.tag, " R10 busy"}, {15'd0, req_busy}, {15'd0, e.busy});
    chk({e.tag, " R10 done"}, {15'd0, req_done}, {15'd0, e.done});
    if (e.chk_rd) chk({e.tag, " R9 rdata"}, rsp_rdata, e.rd);
    bus_ad_i  = e.din;
    idle_now  = !e.busy;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!idle_now) tick();
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] wd, input logic wr,
                       input logic f, input logic word, input logic pinw, input string tag);
    logic wide, split;
    logic [W-1:0] rexp;
    exp_t e;
    wait_idle();
    pin_buswide = pinw;
    req_addr = a; req_wdata = wd; req_write = wr; req_fetch = f; req_word = word;
    req_valid = 1'b1;
    wide  = cfg_width_en & pinw;
    split = word & ~wide;
    if (split) begin
      push_cycle({a[15:1], 1'b0}, {8'h00, wd[7:0]},  wr, f, tag);
      push_cycle({a[15:1], 1'b1}, {8'h00, wd[15:8]}, wr, f, tag);
      rexp = {mem({a[15:1], 1'b1}) & 16'h00FF, 8'h00} | {8'h00, mem({a[15:1], 1'b0})[7:0]};
    end else if (word) begin
      push_cycle(a, wd, wr, f, tag);
      rexp = mem(a);
    end else begin
      push_cycle(a, {8'h00, wd[7:0]}, wr, f, tag);
      rexp = {8'h00, mem(a)[7:0]};
    end
    e = idle_e(); e.done = 1; e.chk_rd = ~wr; e.rd = rexp; e.tag = tag;
    q.push_back(e);
    idle_now = 0;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_wdata = '0; req_write = 0;
    req_fetch = 0; req_word = 0; cfg_ale_mode = 1; cfg_width_en = 1;
    cfg_clkout_dis = 0; pin_buswide = 1; bus_ad_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_n reset", {15'd0, rd_n}, 16'd1);
    chk("R1 wr_n reset", {15'd0, wr_n}, 16'd1);
    chk("R1 oe reset", {15'd0, bus_ad_oe}, 16'd0);
    chk("R1 astb reset", {15'd0, astb}, 16'd0);
    chk("R1 busy reset", {15'd0, req_busy}, 16'd0);
    chk("R11 clk reset", {15'd0, clk_half}, 16'd0);
    rst_n = 1; exp_ck = 0; idle_now = 1;
    tick();

    // R7 16-bit fetch read, R6
    issue(16'h1234, 16'h0, 0, 1, 1, 1, "R7");
    // R3 16-bit data write
    issue(16'h2000, 16'hBEEF, 1, 0, 1, 1, "R3");
    // R9 split read on narrow pin
    issue(16'h3456, 16'h0, 0, 1, 1, 0, "R9");
    wait_idle();
    cfg_ale_mode = 0;
    // R5 address-valid mode, split write at odd address
    issue(16'h4001, 16'hA55A, 1, 0, 1, 0, "R5");
    wait_idle();
    cfg_width_en = 0;
    // R8 pin ignored when disabled
    issue(16'h5002, 16'h0, 0, 0, 1, 1, "R8");
    wait_idle();
    cfg_width_en = 1; cfg_ale_mode = 1;
    // R12 byte read, single cycle
    issue(16'h6003, 16'h0, 0, 0, 0, 1, "R12");
    // R10 requests while busy are dropped
    issue(16'h7010, 16'h0, 0, 1, 1, 1, "R10");
    for (int i = 0; i < 3; i++) begin
      tick();
      req_addr = 16'hFFFF; req_write = 1; req_valid = 1'b1;
    end
    // R10 back-to-back at the done cycle
    issue(16'h8100, 16'h1357, 1, 0, 0, 1, "R10");
    issue(16'h8200, 16'h0, 0, 0, 1, 0, "R10");
    wait_idle();
    // R11 clock output hold then resume
    cfg_clkout_dis = 1;
    repeat (4) tick();
    cfg_clkout_dis = 0;
    repeat (4) tick();
    issue(16'h9ABC, 16'h0, 0, 1, 1, 1, "R6");
    repeat (8) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule